// File: doc/BRIEF.md
# Debug Break Match Channel

This block is a single comparison channel for an on-chip debug break unit. It watches the stream of processor bus accesses. When an access satisfies every programmed condition, it raises a one-clock break request. The conditions are:

- an 8-bit address-space identifier, which is always compared;
- the kind of cycle to watch, either instruction fetch or operand access;
- an operand-size selector;
- an optional data-value comparison.

The size and data conditions only take part on operand-access cycles. The channel can also require a programmed number of qualifying accesses before it fires.

Software programs the channel through a small synchronous register port with word addresses. A sequencer built as a three-state machine turns qualifying accesses ("hits") into break pulses. Its states are:

- `ST_IDLE`: the match counter is zero.
- `ST_ACCUM`: some hits have been counted, but not yet enough.
- `ST_FIRE`: the break request is high for this one clock.

The machine moves as follows:

- **fire**: a hit when counting is off, or the hit that brings the count to the target, sends it to `ST_FIRE` and clears the counter.
- **count**: any other hit with counting on sends it to `ST_ACCUM`.
- **clear**: a write to the count-target register sends it to `ST_IDLE`.
- **settle**: a cycle without a hit returns it to `ST_ACCUM` or `ST_IDLE`, depending on whether the counter is nonzero.

Top module: `brk_match_channel`

## Requirements
- R1: After synchronous reset, `brk_req` is 0, every register reads 0, and the match counter is 0.
- R2: The register map is as follows:
  - Word 0 is the control register. Bits [7:0] hold the identifier. Bit 8 selects the cycle type (0 = instruction fetch, 1 = operand access). Bit 9 enables the data compare. Bits [12:10] hold the size selector. Bit 13 enables counting. Bits [31:14] read 0 and ignore writes.
  - Word 1 holds the 32-bit compare value.
  - Word 2 holds the 12-bit count target in bits [11:0]. Its upper bits read 0.
  - Word 3 reads 0.
  - `cfg_rdata` shows the addressed word in the cycle after `cfg_rd_en` is sampled.
- R3: An access is a hit only if `bus_asid` equals the programmed identifier.
- R4: An access is a hit only if `bus_is_operand` equals the cycle-type bit.
- R5: On operand cycles, the size selector works as follows. 000 accepts any `bus_size`. 001 (byte), 010 (word), 011 (longword) and 100 (quadword) accept only a `bus_size` with the same code.
- R6: Selector codes 101–111 never produce a hit on operand cycles. On fetch cycles the size selector, reserved codes included, has no effect.
- R7: When the data enable is 1 on an operand cycle, `bus_data` must equal the compare value. When the enable is 0, or on fetch cycles, the data value has no effect.
- R8: With counting disabled, every hit on a cycle with `bus_valid` high makes `brk_req` high for exactly the next clock. Hits on consecutive cycles give consecutive pulses.
- R9: With counting enabled and a target N from 1 to 4095, the Nth hit fires a single pulse and the counter restarts at 0. The next pulse needs N further hits.
- R10: A write to word 2 clears the match counter. A hit in the same cycle as that write is discarded: it is neither counted nor fired.
- R11: Accesses that are not hits, and cycles with `bus_valid` low, leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, registered |
| bus_valid | input | 1 | Access present this cycle |
| bus_is_operand | input | 1 | 1 = operand access, 0 = instruction fetch |
| bus_asid | input | 8 | Identifier of the access |
| bus_size | input | 3 | Operand size code of the access |
| bus_data | input | 32 | Data value of the access |
| brk_req | output | 1 | One-clock break request |

## Verification
Two of the block's functions can land on the same clock edge: a register write that clears the match counter, and a hit that would advance or complete the count. The bench provokes the collision directly:

1. It counts two hits toward a target of three.
2. It drives a word-2 write and a qualifying access on the same clock.
3. It checks that no pulse appears.
4. It checks that exactly three further hits are then needed before the break fires.

If the sequencer counted or fired on the colliding hit, the pulse would come one hit early, so that ordering is judged at the output pin alone.

// File: rtl/brk_pkg.sv
package brk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_FIRE  = 2'd2
    } brk_state_e;

    localparam logic [1:0] ADR_CTRL  = 2'd0;
    localparam logic [1:0] ADR_VALUE = 2'd1;
    localparam logic [1:0] ADR_COUNT = 2'd2;

    localparam logic [2:0] SZ_ANY  = 3'd0;
    localparam logic [2:0] SZ_QUAD = 3'd4;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int ASID_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [ASID_W-1:0] asid,
    output logic              cyc_op,
    output logic              data_en,
    output logic [2:0]        size_sel,
    output logic              cnt_en,
    output logic [DATA_W-1:0] value,
    output logic [CNT_W-1:0]  target,
    output logic              target_wr
);
    localparam int CYC_BIT = ASID_W;
    localparam int DEN_BIT = ASID_W + 1;
    localparam int SZ_LSB  = ASID_W + 2;
    localparam int CEN_BIT = ASID_W + 5;

    assign target_wr = wr_en && (addr == ADR_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            asid     <= '0;
            cyc_op   <= 1'b0;
            data_en  <= 1'b0;
            size_sel <= '0;
            cnt_en   <= 1'b0;
            value    <= '0;
            target   <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADR_CTRL: begin
                    asid     <= wdata[ASID_W-1:0];
                    cyc_op   <= wdata[CYC_BIT];
                    data_en  <= wdata[DEN_BIT];
                    size_sel <= wdata[SZ_LSB +: 3];
                    cnt_en   <= wdata[CEN_BIT];
                end
                ADR_VALUE: value  <= wdata[DATA_W-1:0];
                ADR_COUNT: target <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= '0;
            unique case (addr)
                ADR_CTRL: begin
                    rdata[ASID_W-1:0]  <= asid;
                    rdata[CYC_BIT]     <= cyc_op;
                    rdata[DEN_BIT]     <= data_en;
                    rdata[SZ_LSB +: 3] <= size_sel;
                    rdata[CEN_BIT]     <= cnt_en;
                end
                ADR_VALUE: rdata[DATA_W-1:0] <= value;
                ADR_COUNT: rdata[CNT_W-1:0]  <= target;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/brk_qualify.sv
module brk_qualify
    import brk_pkg::*;
#(
    parameter int ASID_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              bus_valid,
    input  logic              bus_is_operand,
    input  logic [ASID_W-1:0] bus_asid,
    input  logic [2:0]        bus_size,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [ASID_W-1:0] asid,
    input  logic              cyc_op,
    input  logic              data_en,
    input  logic [2:0]        size_sel,
    input  logic [DATA_W-1:0] value,
    output logic              hit
);
    logic size_ok;
    logic data_ok;
    logic common_ok;

    always_comb begin
        if (size_sel == SZ_ANY)
            size_ok = 1'b1;
        else if (size_sel <= SZ_QUAD)
            size_ok = (bus_size == size_sel);
        else
            size_ok = 1'b0;
    end

    assign data_ok   = !data_en || (bus_data == value);
    assign common_ok = bus_valid && (bus_asid == asid) && (bus_is_operand == cyc_op);
    assign hit       = common_ok && (!bus_is_operand || (size_ok && data_ok));
endmodule

// File: rtl/brk_seq.sv
module brk_seq
    import brk_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] target,
    input  logic             clr,
    output logic             brk_req
);
    brk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (hit && (!cnt_en || (cnt_inc == target))) begin
            state_d = ST_FIRE;
            cnt_d   = '0;
        end else if (hit) begin
            state_d = ST_ACCUM;
            cnt_d   = cnt_inc;
        end else begin
            state_d = (cnt_q != '0) ? ST_ACCUM : ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  brk_req = 1'b0;
            ST_ACCUM: brk_req = 1'b0;
            ST_FIRE:  brk_req = 1'b1;
            default:  brk_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/brk_match_channel.sv
module brk_match_channel
    import brk_pkg::*;
#(
    parameter int ASID_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_rd_en,
    input  logic [1:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              bus_valid,
    input  logic              bus_is_operand,
    input  logic [ASID_W-1:0] bus_asid,
    input  logic [2:0]        bus_size,
    input  logic [DATA_W-1:0] bus_data,
    output logic              brk_req
);
    logic [ASID_W-1:0] c_asid;
    logic              c_cyc_op;
    logic              c_data_en;
    logic [2:0]        c_size;
    logic              c_cnt_en;
    logic [DATA_W-1:0] c_value;
    logic [CNT_W-1:0]  c_target;
    logic              clr_cnt;
    logic              hit;

    brk_regs #(.ASID_W(ASID_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .rd_en(cfg_rd_en), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .asid(c_asid), .cyc_op(c_cyc_op),
        .data_en(c_data_en), .size_sel(c_size), .cnt_en(c_cnt_en), .value(c_value),
        .target(c_target), .target_wr(clr_cnt)
    );

    brk_qualify #(.ASID_W(ASID_W), .DATA_W(DATA_W)) u_qual (
        .bus_valid(bus_valid), .bus_is_operand(bus_is_operand), .bus_asid(bus_asid),
        .bus_size(bus_size), .bus_data(bus_data), .asid(c_asid), .cyc_op(c_cyc_op),
        .data_en(c_data_en), .size_sel(c_size), .value(c_value), .hit(hit)
    );

    brk_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .hit(hit), .cnt_en(c_cnt_en), .target(c_target),
        .clr(clr_cnt), .brk_req(brk_req)
    );
endmodule

// File: rtl/brk_match_chk.sv
module brk_match_chk #(
    parameter int ASID_W = 8,
    parameter int REG_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic              cfg_rd_en,
    input logic [1:0]        cfg_addr,
    input logic [REG_W-1:0]  cfg_rdata,
    input logic              bus_valid,
    input logic              bus_is_operand,
    input logic [ASID_W-1:0] bus_asid,
    input logic [ASID_W-1:0] cfg_asid,
    input logic              cfg_cyc_op,
    input logic [2:0]        cfg_size,
    input logic              brk_req
);
    localparam int CTL_USED = ASID_W + 6;

    AST_PULSE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> $past(bus_valid)); // R8
    AST_ASID_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_asid != cfg_asid) |=> !brk_req); // R3
    AST_CYCLE_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_is_operand != cfg_cyc_op) |=> !brk_req); // R4
    AST_RESERVED_SIZE: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_is_operand && cfg_size > 3'd4) |=> !brk_req); // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_addr == 2'd2) |=> !brk_req); // R10
    AST_CTRL_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_en && cfg_addr == 2'd0) |=> (cfg_rdata[REG_W-1:CTL_USED] == '0)); // R2
endmodule

bind brk_match_channel brk_match_chk #(.ASID_W(ASID_W), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .bus_valid(bus_valid),
    .bus_is_operand(bus_is_operand), .bus_asid(bus_asid), .cfg_asid(c_asid),
    .cfg_cyc_op(c_cyc_op), .cfg_size(c_size), .brk_req(brk_req)
);

// File: tb/test_brk_match_channel.sv
`timescale 1ns/1ps
module test_brk_match_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_valid = 1'b0, bus_is_operand = 1'b0;
    logic [7:0]  bus_asid = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_data = '0;
    logic        brk_req;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    brk_match_channel i_brk_match_channel (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_valid(bus_valid), .bus_is_operand(bus_is_operand), .bus_asid(bus_asid),
        .bus_size(bus_size), .bus_data(bus_data), .brk_req(brk_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        cfg_rd_en = 1'b1; cfg_addr = a;
        step();
        cfg_rd_en = 1'b0;
        check(tag, cfg_rdata, exp);
    endtask

    function automatic logic [31:0] ctl(input logic [7:0] asid, input logic op,
                                        input logic den, input logic [2:0] sz, input logic cen);
        return {18'd0, cen, sz, den, op, asid};
    endfunction

    task automatic drive(input logic op, input logic [7:0] asid, input logic [2:0] sz,
                         input logic [31:0] d);
        bus_valid = 1'b1; bus_is_operand = op; bus_asid = asid; bus_size = sz; bus_data = d;
    endtask

    // one access, pulse checked in the following cycle, then low afterwards
    task automatic access(input logic op, input logic [7:0] asid, input logic [2:0] sz,
                          input logic [31:0] d, input logic exp, input string tag);
        drive(op, asid, sz, d);
        step();
        bus_valid = 1'b0;
        check(tag, {31'd0, brk_req}, {31'd0, exp});
        step();
        check({tag, " (width R8)"}, {31'd0, brk_req}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 brk_req after reset", {31'd0, brk_req}, 32'd0);
        rd(2'd0, 32'd0, "R1 ctrl reset");
        rd(2'd1, 32'd0, "R1 value reset");
        rd(2'd2, 32'd0, "R1 count reset");
        access(1'b0, 8'h00, 3'd0, 32'd0, 1'b1, "R1 default config fires on id 0 fetch");
    endtask

    task automatic t_regs();
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 32'h0000_3FFF, "R2 ctrl reserved bits");
        wr(2'd1, 32'hA5C3_0F1E);
        rd(2'd1, 32'hA5C3_0F1E, "R2 value word");
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, 32'h0000_0FFF, "R2 count word");
        wr(2'd3, 32'h1234_5678);
        rd(2'd3, 32'd0, "R2 word 3 reads zero");
        rd(2'd0, 32'h0000_3FFF, "R2 ctrl kept after word 3 write");
        wr(2'd2, 32'd0);
    endtask

    task automatic t_asid();
        wr(2'd0, ctl(8'h5A, 1'b0, 1'b0, 3'd0, 1'b0));
        access(1'b0, 8'h5A, 3'd0, 32'd0, 1'b1, "R3 id equal");
        access(1'b0, 8'h5B, 3'd0, 32'd0, 1'b0, "R3 id differs");
    endtask

    task automatic t_cycle();
        access(1'b1, 8'h5A, 3'd0, 32'd0, 1'b0, "R4 operand vs fetch select");
        wr(2'd0, ctl(8'h5A, 1'b1, 1'b0, 3'd0, 1'b0));
        access(1'b0, 8'h5A, 3'd0, 32'd0, 1'b0, "R4 fetch vs operand select");
        access(1'b1, 8'h5A, 3'd3, 32'd0, 1'b1, "R4 operand vs operand select");
    endtask

    task automatic t_size();
        wr(2'd0, ctl(8'h11, 1'b1, 1'b0, 3'd2, 1'b0));
        access(1'b1, 8'h11, 3'd2, 32'd0, 1'b1, "R5 word selector word access");
        access(1'b1, 8'h11, 3'd1, 32'd0, 1'b0, "R5 word selector byte access");
        wr(2'd0, ctl(8'h11, 1'b1, 1'b0, 3'd4, 1'b0));
        access(1'b1, 8'h11, 3'd4, 32'd0, 1'b1, "R5 quad selector quad access");
        wr(2'd0, ctl(8'h11, 1'b1, 1'b0, 3'd0, 1'b0));
        access(1'b1, 8'h11, 3'd3, 32'd0, 1'b1, "R5 any selector long access");
    endtask

    task automatic t_reserved();
        wr(2'd0, ctl(8'h11, 1'b1, 1'b0, 3'd5, 1'b0));
        access(1'b1, 8'h11, 3'd5, 32'd0, 1'b0, "R6 reserved selector operand");
        wr(2'd0, ctl(8'h11, 1'b0, 1'b0, 3'd7, 1'b0));
        access(1'b0, 8'h11, 3'd1, 32'd0, 1'b1, "R6 reserved selector ignored on fetch");
    endtask

    task automatic t_data();
        wr(2'd1, 32'hDEAD_BEEF);
        wr(2'd0, ctl(8'h22, 1'b1, 1'b1, 3'd0, 1'b0));
        access(1'b1, 8'h22, 3'd3, 32'hDEAD_BEEF, 1'b1, "R7 data equal");
        access(1'b1, 8'h22, 3'd3, 32'hDEAD_BEEE, 1'b0, "R7 data differs");
        wr(2'd0, ctl(8'h22, 1'b1, 1'b0, 3'd0, 1'b0));
        access(1'b1, 8'h22, 3'd3, 32'h0000_0001, 1'b1, "R7 data ignored when disabled");
        wr(2'd0, ctl(8'h22, 1'b0, 1'b1, 3'd0, 1'b0));
        access(1'b0, 8'h22, 3'd0, 32'h0000_0001, 1'b1, "R7 data ignored on fetch");
    endtask

    task automatic t_back_to_back();
        wr(2'd0, ctl(8'h33, 1'b0, 1'b0, 3'd0, 1'b0));
        drive(1'b0, 8'h33, 3'd0, 32'd0);
        step();
        check("R8 first of two pulses", {31'd0, brk_req}, 32'd1);
        step();
        bus_valid = 1'b0;
        check("R8 second of two pulses", {31'd0, brk_req}, 32'd1);
        step();
        check("R8 pulse ends", {31'd0, brk_req}, 32'd0);
    endtask

    task automatic t_count();
        wr(2'd2, 32'd3);
        wr(2'd0, ctl(8'h44, 1'b0, 1'b0, 3'd0, 1'b1));
        access(1'b0, 8'h44, 3'd0, 32'd0, 1'b0, "R9 hit 1 of 3");
        access(1'b0, 8'h45, 3'd0, 32'd0, 1'b0, "R11 non-hit");
        access(1'b0, 8'h44, 3'd0, 32'd0, 1'b0, "R9 hit 2 of 3");
        access(1'b1, 8'h44, 3'd0, 32'd0, 1'b0, "R11 wrong cycle non-hit");
        access(1'b0, 8'h44, 3'd0, 32'd0, 1'b1, "R9 hit 3 of 3 fires");
        access(1'b0, 8'h44, 3'd0, 32'd0, 1'b0, "R9 restart hit 1");
        access(1'b0, 8'h44, 3'd0, 32'd0, 1'b0, "R9 restart hit 2");
        access(1'b0, 8'h44, 3'd0, 32'd0, 1'b1, "R9 restart hit 3 fires");
    endtask

    task automatic t_clear_collision();
        access(1'b0, 8'h44, 3'd0, 32'd0, 1'b0, "R10 pre hit 1");
        access(1'b0, 8'h44, 3'd0, 32'd0, 1'b0, "R10 pre hit 2");
        cfg_wr_en = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'd3;
        drive(1'b0, 8'h44, 3'd0, 32'd0);
        step();
        cfg_wr_en = 1'b0; bus_valid = 1'b0;
        check("R10 hit with count write discarded", {31'd0, brk_req}, 32'd0);
        step();
        access(1'b0, 8'h44, 3'd0, 32'd0, 1'b0, "R10 after clear hit 1");
        access(1'b0, 8'h44, 3'd0, 32'd0, 1'b0, "R10 after clear hit 2");
        access(1'b0, 8'h44, 3'd0, 32'd0, 1'b1, "R10 after clear hit 3 fires");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_asid();
        t_cycle();
        t_size();
        t_reserved();
        t_data();
        t_back_to_back();
        t_count();
        t_clear_collision();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule